// File: doc/BRIEF.md
# Ethernet Transmit Pad and Frame Check Inserter

This block sits in a transmit path between the application and the medium side. The application streams a frame one byte per beat: destination, source, type/length and payload, in that order. The block forwards those bytes unchanged. The source address is always taken from the stream and never replaced. After the last application byte, the block can add two things. First, zero bytes that bring the frame up to the 60-byte minimum. Second, a 32-bit frame check sequence computed over every byte sent so far.

Both additions are set by a 2-bit mode input, which is captured on the first byte of each frame. When padding is off, a short frame goes out exactly as given and nothing blocks it. When the check sequence is off, the application's own trailing bytes leave untouched and serve as the check value. Both sides use a valid/ready byte handshake. The input is held off while the block emits its own bytes.

Top module: `txfcs_insert`

## Requirements
- R1: After reset the block is in the data phase: `m_valid` is low while `s_valid` is low, and `s_ready` equals `m_ready`.
- R2: During the data phase each accepted input byte appears on the output in the same cycle and in the same order, with its value unchanged.
- R3: With padding enabled, a frame of fewer than 60 input bytes is followed by zero bytes (value 0x00) until exactly 60 bytes precede the check sequence.
- R4: With padding enabled, a frame of 60 or more input bytes gets no zero bytes.
- R5: With the check sequence enabled, four bytes follow the data and padding. They hold the CRC-32 over all preceding bytes: reflected polynomial 0xEDB88320, register preset to all ones, processed least significant bit first, complemented at the end, and sent least significant byte first.
- R6: Mode code 00 adds nothing: the output is exactly the input frame, even when it is shorter than 60 bytes, and the end marker is on the last input byte.
- R7: Mode code 01 appends only the check sequence; a short frame is not padded.
- R8: `s_ready` is low in every cycle in which padding or check bytes are being emitted.
- R9: `m_last` is high on exactly one beat per frame: the final check byte when the check sequence is on, otherwise the last input byte.
- R10: While `m_valid` is high and `m_ready` is low, the block-generated output byte and end marker hold their values until the next cycle.
- R11: The mode is sampled with the first byte of a frame; a change of `cfg_mode` later in the same frame has no effect on that frame.
- R12: Mode code 10 behaves as code 11, which pads to 60 bytes and appends the check sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Insertion mode: 00 none, 01 check only, 10/11 pad and check |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte is the last of the frame |
| s_ready | output | 1 | Block accepts the input byte |
| m_valid | output | 1 | Output byte valid |
| m_data | output | 8 | Output byte |
| m_last | output | 1 | Output byte ends the frame |
| m_ready | input | 1 | Downstream accepts the output byte |

## Verification
Two decisions meet on the same edge: the final application byte is accepted, and the byte count decides whether padding follows it. In the same cycle, the last pad byte also moves the block into check-byte output. The bench provokes this boundary with frames of 59, 60 and 61 bytes and with a single-byte frame, both with and without downstream stalls. It judges each case by the exact output length, the position of the single end marker and a check value recomputed by a bit-serial model of its own.

// File: rtl/txfcs_pkg.sv
package txfcs_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned FCS_BYTES = CRC_W / BYTE_W;
  localparam int unsigned FCS_IDX_W = $clog2(FCS_BYTES);
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    PH_DATA = 2'd0,
    PH_PAD  = 2'd1,
    PH_FCS  = 2'd2
  } phase_t;

  typedef struct packed {
    logic pad_en;
    logic crc_en;
  } mode_t;

  // 00: none, 01: check only, 1x: pad and check
  function automatic mode_t decode_mode(input logic [1:0] code);
    mode_t m;
    m.pad_en = code[1];
    m.crc_en = code[1] | code[0];
    return m;
  endfunction

  // one byte through the reflected CRC register, lsb first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] c;
    c = cur ^ {{(CRC_W-BYTE_W){1'b0}}, din};
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

  // byte idx of the complemented register, least significant first
  function automatic logic [BYTE_W-1:0] fcs_byte(input logic [CRC_W-1:0] cur,
                                                 input logic [FCS_IDX_W-1:0] idx);
    logic [CRC_W-1:0] inv;
    inv = ~cur;
    return inv[idx*BYTE_W +: BYTE_W];
  endfunction

endpackage

// File: rtl/txfcs_crc.sv
module txfcs_crc
  import txfcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)      crc_d = CRC_SEED;
    else if (upd) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

endmodule

// File: rtl/txfcs_len.sv
module txfcs_len #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             is_first,
  output logic             below_min
);

  localparam logic [CNT_W-1:0] LAST_MIN_IDX = CNT_W'(MIN_FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_MAX      = {CNT_W{1'b1}};

  // cnt_q counts bytes already sent; the current byte is number cnt_q+1
  assign is_first  = (cnt_q == '0);
  assign below_min = (cnt_q < LAST_MIN_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr)                    cnt_q <= '0;
    else if (inc && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/txfcs_insert.sv
module txfcs_insert
  import txfcs_pkg::*;
#(
  parameter int unsigned MIN_FRAME = 60,
  parameter int unsigned CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              s_valid,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  input  logic              m_ready
);

  localparam logic [FCS_IDX_W-1:0] FCS_LAST = FCS_IDX_W'(FCS_BYTES - 1);

  phase_t                phase_q, phase_d;
  mode_t                 mode_q, mode_eff;
  logic [FCS_IDX_W-1:0]  fcs_idx_q;
  logic [CRC_W-1:0]      crc_q;
  logic [CNT_W-1:0]      len_cnt;
  logic                  first_byte, below_min;

  // named events for checking
  logic beat_in, beat_out, data_last, pad_beat, pad_done;
  logic fcs_beat, fcs_done, frame_end, fill_busy;

  assign mode_eff = (phase_q == PH_DATA && first_byte) ? decode_mode(cfg_mode) : mode_q;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = '0;
    m_last  = 1'b0;
    unique case (phase_q)
      PH_DATA: begin
        s_ready = m_ready;
        m_valid = s_valid;
        m_data  = s_data;
        m_last  = s_last && !mode_eff.crc_en;
      end
      PH_PAD: begin
        m_valid = 1'b1;
        m_data  = '0;
      end
      PH_FCS: begin
        m_valid = 1'b1;
        m_data  = fcs_byte(crc_q, fcs_idx_q);
        m_last  = (fcs_idx_q == FCS_LAST);
      end
      default: ;
    endcase
  end

  assign beat_in   = s_valid && s_ready;
  assign beat_out  = m_valid && m_ready;
  assign data_last = beat_in && s_last;
  assign fill_busy = (phase_q != PH_DATA);
  assign pad_beat  = (phase_q == PH_PAD) && m_ready;
  assign pad_done  = pad_beat && !below_min;
  assign fcs_beat  = (phase_q == PH_FCS) && m_ready;
  assign fcs_done  = fcs_beat && (fcs_idx_q == FCS_LAST);
  assign frame_end = (data_last && !mode_eff.crc_en) || fcs_done;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_DATA: if (data_last) begin
        if (mode_eff.pad_en && below_min) phase_d = PH_PAD;
        else if (mode_eff.crc_en)         phase_d = PH_FCS;
      end
      PH_PAD:  if (pad_done) phase_d = PH_FCS;
      PH_FCS:  if (fcs_done) phase_d = PH_DATA;
      default: phase_d = PH_DATA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_DATA;
      mode_q    <= '0;
      fcs_idx_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (beat_in && first_byte) mode_q <= mode_eff;
      if (fcs_beat)              fcs_idx_q <= fcs_idx_q + 1'b1;
    end
  end

  txfcs_crc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_end),
    .upd   (beat_in || pad_beat),
    .din   (m_data),
    .crc_q (crc_q)
  );

  txfcs_len #(
    .CNT_W     (CNT_W),
    .MIN_FRAME (MIN_FRAME)
  ) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (frame_end),
    .inc       (beat_in || pad_beat),
    .cnt_q     (len_cnt),
    .is_first  (first_byte),
    .below_min (below_min)
  );

endmodule

// File: rtl/txfcs_insert_chk.sv
module txfcs_insert_chk #(
  parameter int unsigned MIN_FRAME = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic [7:0] s_data,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       pad_beat,
  input logic       fcs_beat,
  input logic       fill_busy,
  input logic       cur_pad
);

  localparam logic [15:0] MIN_BEFORE_LAST = 16'(MIN_FRAME + 3);

  logic [15:0] obeats;

  always_ff @(posedge clk) begin
    if (!rst_n) obeats <= '0;
    else if (m_valid && m_ready) begin
      if (m_last)               obeats <= '0;
      else if (obeats != 16'hFFFF) obeats <= obeats + 1'b1;
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (m_valid && m_data == s_data));

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_beat |-> (m_data == 8'h00 && !m_last && !s_ready));

  p_min_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last && cur_pad) |-> (obeats >= MIN_BEFORE_LAST));

  p_no_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !s_ready);

  p_more_fcs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_beat && !m_last) |=> fill_busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

endmodule

bind txfcs_insert txfcs_insert_chk #(.MIN_FRAME(MIN_FRAME)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_data    (s_data),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_last    (m_last),
  .pad_beat  (pad_beat),
  .fcs_beat  (fcs_beat),
  .fill_busy (fill_busy),
  .cur_pad   (mode_eff.pad_en)
);

// File: tb/txfcs_insert_bench.sv
module txfcs_insert_bench;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       m_valid;
  logic [7:0] m_data;
  logic       m_last;
  logic       m_ready = 1'b1;

  int total = 0;
  int bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  txfcs_insert u_txfcs_insert (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bit-serial model: feedback taken per bit
  function automatic logic [31:0] model_crc(input logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (q[i]) begin
      for (int k = 0; k < 8; k++) begin
        logic fb;
        fb = c[0] ^ q[i][k];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed + i * 13) ^ (i >> 3));
  endfunction

  task automatic run_frame(input string req, input int len, input logic [1:0] mode,
                           input logic [1:0] mode_mid, input bit stall, input int seed);
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    logic [31:0] crc;
    int sent = 0, cyc = 0, nlast = 0, last_pos = -1, ready_bad = 0, hold_bad = 0;
    bit offered = 0, held = 0, done = 0, pad_on, crc_on;
    logic [7:0] held_data;
    logic       held_last;
    pad_on = mode[1];
    crc_on = mode[1] | mode[0];
    for (int i = 0; i < len; i++) exp_q.push_back(pat(seed, i));
    if (pad_on) while (exp_q.size() < 60) exp_q.push_back(8'h00);
    if (crc_on) begin
      crc = model_crc(exp_q);
      for (int b = 0; b < 4; b++) exp_q.push_back(crc[8*b +: 8]);
    end
    cfg_mode = mode;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      if (sent < len) begin
        if (!offered) s_valid = stall ? ((cyc % 3) != 1) : 1'b1;
        s_data = pat(seed, sent);
        s_last = (sent == len - 1);
      end else begin
        s_valid = 1'b0;
        s_last  = 1'b0;
      end
      m_ready = stall ? ((cyc % 4) != 2) : 1'b1;
      if (sent >= 1) cfg_mode = mode_mid;
      #1;
      if (held && sent == len && got_q.size() >= len) begin
        if (!m_valid || m_data != held_data || m_last != held_last) hold_bad++;
      end
      if (sent == len && got_q.size() >= len && s_ready) ready_bad++;
      if (m_valid && m_ready) begin
        got_q.push_back(m_data);
        if (m_last) begin
          nlast++;
          last_pos = got_q.size() - 1;
          done = 1;
        end
      end
      held = m_valid && !m_ready;
      held_data = m_data;
      held_last = m_last;
      if (s_valid && s_ready) begin
        sent++;
        offered = 0;
      end else offered = s_valid;
      cyc++;
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    m_ready = 1'b1;
    if (!done) check(req, "watchdog frame end", 0, 1);
    check(req, "output length", got_q.size(), exp_q.size());
    begin
      int mism = -1;
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
        if (mism < 0 && got_q[i] != exp_q[i]) mism = i;
      if (mism >= 0) check({req, " R2/R5 content"}, "byte value", got_q[mism], exp_q[mism]);
      else check({req, " R2/R5 content"}, "mismatch", 0, 0);
    end
    check({req, " R9"}, "end marker count", nlast, 1);
    check({req, " R9"}, "end marker pos", last_pos, exp_q.size() - 1);
    check({req, " R8"}, "ready during fill", ready_bad, 0);
    check({req, " R10"}, "hold under stall", hold_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    s_valid = 1'b0;
    m_ready = 1'b1;
    #1;
    check("R1", "m_valid idle", m_valid, 0);
    check("R1", "s_ready idle", s_ready, 1);
    m_ready = 1'b0;
    #1;
    check("R1", "s_ready follows m_ready", s_ready, 0);
    m_ready = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_frame("R3", 20, 2'b11, 2'b11, 0, 5);
    run_frame("R3 boundary 59", 59, 2'b11, 2'b11, 0, 17);
    run_frame("R4 boundary 60", 60, 2'b11, 2'b11, 0, 33);
    run_frame("R4 61 stalled", 61, 2'b11, 2'b11, 1, 41);
    run_frame("R3 single byte", 1, 2'b11, 2'b11, 1, 77);
    run_frame("R6", 20, 2'b00, 2'b00, 0, 9);
    run_frame("R6 stalled", 7, 2'b00, 2'b00, 1, 90);
    run_frame("R7", 10, 2'b01, 2'b01, 0, 3);
    run_frame("R7 long stalled", 70, 2'b01, 2'b01, 1, 120);
    run_frame("R12", 20, 2'b10, 2'b10, 0, 61);
    run_frame("R11 mode change", 30, 2'b11, 2'b00, 0, 200);
    run_frame("R11 reverse change", 12, 2'b00, 2'b11, 1, 150);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule